// File: doc/BRIEF.md
# Endian Load/Store Lane Steering Unit

This unit sits between a core's load/store port and a 64-bit memory data bus whose lanes are numbered little-endian. Lane k carries the byte at offset k of the bus word. Each request supplies a byte offset within the bus word, an access size of 1, 2, 4 or 8 bytes, a big-endian flag and an invariance granularity. The granularity is byte (address-invariant) or a 16-, 32- or 64-bit datum (data-invariant). From these inputs the unit produces byte enables and lane-placed store data in the same cycle. It also records how the returning load word must be unpacked.

Memory returns the load word one cycle after an aligned load request is accepted. A two-state machine handles the response. ST_IDLE moves to ST_RESP on a clock edge that accepts an aligned load. ST_RESP stays in ST_RESP if another aligned load is accepted on that edge, and otherwise returns to ST_IDLE. While the machine is in ST_RESP, `ld_valid` is high and `ld_data` holds the selected bytes, right-justified and zero-extended. Misaligned requests raise `misalign` and touch no lane.

Top module: `endian_steer`

## Requirements
- R1: With `big_endian`=0 the first lane is the offset. The value is assembled with the lowest lane least significant. `inv_sel` has no effect on lanes or data.
- R2: With `big_endian`=1 and `inv_sel`=0 (byte-invariant), lanes equal the little-endian lanes and the lowest address byte is most significant. A single-byte access returns the same byte in both modes.
- R3: With `big_endian`=1 and `inv_sel`=1/2/3 (datum of 2/4/8 bytes), an access narrower than the datum uses first lane = offset XOR (datum bytes − access bytes). Byte significance is then little-endian.
- R4: An access as wide as or wider than the datum behaves exactly as in little-endian mode.
- R5: A valid request whose offset is not a multiple of its size drives `misalign`=1, `be_out`=0 and `bus_wdata`=0, and causes no load response.
- R6: For an aligned request, `be_out` has 2^`req_size` contiguous ones starting at the first lane. `req_size` encodes 0=1, 1=2, 2=4, 3=8 bytes. For a store, `bus_wdata` carries the steered bytes in the enabled lanes and zero elsewhere.
- R7: `ld_data` bits above the access size are zero.
- R8: `ld_valid` is high in the cycle after an edge that accepted an aligned load (`req_valid`=1, `req_write`=0), and low after any other edge. `ld_data` is taken from `mem_rdata` using the context captured at that edge. Back-to-back loads each get their own context.
- R9: While `rst_n` is low the machine is in ST_IDLE and `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_offset | input | 3 | Byte offset within the bus word |
| req_size | input | 2 | log2 of access bytes |
| big_endian | input | 1 | Big-endian view selected |
| inv_sel | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword invariance |
| st_data | input | 64 | Right-justified store value |
| be_out | output | 8 | Byte lane enables |
| bus_wdata | output | 64 | Lane-placed store data |
| misalign | output | 1 | Misaligned request |
| mem_rdata | input | 64 | Load word from memory, one cycle after the request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Right-justified, zero-extended load result |

## Verification
Loads read a fixed bus word whose eight bytes are all distinct. This makes any wrong lane choice or wrong byte order show up as a different value. Each invariance granularity is tried with sizes below, equal to and above its datum size. These cases separate the XOR lane flip from the plain byte swap and from the pass-through case. Stores use a right-justified value with distinct bytes to show both lane placement and zeroing of unused lanes. Misaligned offsets and a back-to-back load pair check suppression and the per-request capture of context.

// File: rtl/endian_pkg.sv
package endian_pkg;
    localparam int BUS_BYTES = 8;
    localparam int LANE_W    = $clog2(BUS_BYTES);
    localparam int BUS_W     = 8 * BUS_BYTES;
    localparam int SIZE_W    = $clog2(LANE_W + 1);

    typedef enum logic [1:0] {
        INV_BYTE  = 2'd0,
        INV_HALF  = 2'd1,
        INV_WORD  = 2'd2,
        INV_DWORD = 2'd3
    } inv_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;
endpackage

// File: rtl/endian_lane_map.sv
module endian_lane_map
    import endian_pkg::*;
(
    input  logic [LANE_W-1:0] offset,
    input  logic [SIZE_W-1:0] size,
    input  logic              big_endian,
    input  inv_e              inv,
    output logic [LANE_W-1:0] lane,
    output logic              swap,
    output logic              misalign
);
    logic [LANE_W-1:0] size_mask;
    logic [LANE_W-1:0] flip;

    always_comb begin
        size_mask = LANE_W'((1 << size) - 1);
        flip      = LANE_W'((1 << inv) - (1 << size));
        misalign  = |(offset & size_mask);
        lane      = offset;
        swap      = 1'b0;
        if (big_endian) begin
            if (inv == INV_BYTE) begin
                swap = 1'b1;
            end else if (SIZE_W'(inv) > size) begin
                lane = offset ^ flip;
            end
        end
    end
endmodule

// File: rtl/endian_byte_order.sv
module endian_byte_order
    import endian_pkg::*;
(
    input  logic [BUS_W-1:0]  din,
    input  logic [SIZE_W-1:0] size,
    input  logic              reverse,
    output logic [BUS_W-1:0]  dout
);
    always_comb begin
        int nb;
        nb   = 1 << size;
        dout = '0;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (i < nb) begin
                if (reverse)
                    dout[8*i +: 8] = din[8*(nb-1-i) +: 8];
                else
                    dout[8*i +: 8] = din[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/endian_steer.sv
module endian_steer
    import endian_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LANE_W-1:0] req_offset,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              big_endian,
    input  logic [1:0]        inv_sel,
    input  logic [BUS_W-1:0]  st_data,
    output logic [BUS_BYTES-1:0] be_out,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic              misalign,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic              ld_valid,
    output logic [BUS_W-1:0]  ld_data
);
    logic [LANE_W-1:0]    lane;
    logic                 swap;
    logic                 bad_align;
    logic [BUS_W-1:0]     st_packed;
    logic [BUS_BYTES-1:0] size_be;
    logic                 load_take;

    resp_state_e          state_q, state_d;
    logic [LANE_W-1:0]    ctx_lane_q;
    logic [SIZE_W-1:0]    ctx_size_q;
    logic                 ctx_swap_q;
    logic [BUS_W-1:0]     rd_shifted;

    endian_lane_map u_map (
        .offset     (req_offset),
        .size       (req_size),
        .big_endian (big_endian),
        .inv        (inv_e'(inv_sel)),
        .lane       (lane),
        .swap       (swap),
        .misalign   (bad_align)
    );

    endian_byte_order u_st_order (
        .din     (st_data),
        .size    (req_size),
        .reverse (swap),
        .dout    (st_packed)
    );

    always_comb begin
        size_be   = BUS_BYTES'({BUS_BYTES{1'b1}} >> (BUS_BYTES - (1 << req_size)));
        misalign  = req_valid && bad_align;
        load_take = req_valid && !req_write && !bad_align;
        if (req_valid && !bad_align) begin
            be_out    = size_be << lane;
            bus_wdata = req_write ? (st_packed << {lane, 3'b000}) : '0;
        end else begin
            be_out    = '0;
            bus_wdata = '0;
        end
    end

    // state register and captured load context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ctx_lane_q <= '0;
            ctx_size_q <= '0;
            ctx_swap_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_take) begin
                ctx_lane_q <= lane;
                ctx_size_q <= req_size;
                ctx_swap_q <= swap;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = load_take ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = load_take ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: ld_valid = 1'b0;
            ST_RESP: ld_valid = 1'b1;
            default: ld_valid = 1'b0;
        endcase
        rd_shifted = mem_rdata >> {ctx_lane_q, 3'b000};
    end

    endian_byte_order u_ld_order (
        .din     (rd_shifted),
        .size    (ctx_size_q),
        .reverse (ctx_swap_q),
        .dout    (ld_data)
    );
endmodule

// File: rtl/endian_steer_chk.sv
module endian_steer_chk
    import endian_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [SIZE_W-1:0]    req_size,
    input logic                 misalign,
    input logic [BUS_BYTES-1:0] be_out,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic                 ld_valid,
    input logic [BUS_W-1:0]     ld_data
);
    logic [BUS_W-1:0] lane_mask;
    logic [BUS_W-1:0] size_mask_past;
    logic [SIZE_W-1:0] size_q;

    always_comb begin
        for (int i = 0; i < BUS_BYTES; i++)
            lane_mask[8*i +: 8] = {8{be_out[i]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) size_q <= '0;
        else        size_q <= req_size;
    end

    always_comb size_mask_past = {BUS_W{1'b1}} >> (BUS_W - 8 * (1 << size_q));

    AST_ERR_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (be_out == '0 && bus_wdata == '0)); // R5
    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misalign) |-> ($countones(be_out) == (1 << req_size))); // R6
    AST_WDATA_IN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wdata & ~lane_mask) == '0); // R6
    AST_LOAD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !misalign) |=> ld_valid); // R8
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write && !misalign) |=> !ld_valid); // R8
    AST_ERR_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !ld_valid); // R5
    AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ((ld_data & ~size_mask_past) == '0)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !ld_valid); // R9
endmodule

bind endian_steer endian_steer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .misalign  (misalign),
    .be_out    (be_out),
    .bus_wdata (bus_wdata),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data)
);

// File: tb/endian_steer_test.sv
module endian_steer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, big_endian = 1'b0;
    logic [2:0]  req_offset = '0;
    logic [1:0]  req_size = '0, inv_sel = '0;
    logic [63:0] st_data = 64'h1122334455667788;
    logic [63:0] mem_rdata = 64'h99887766ddccbbaa;
    logic [7:0]  be_out;
    logic [63:0] bus_wdata, ld_data;
    logic        misalign, ld_valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    endian_steer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .big_endian(big_endian),
        .inv_sel(inv_sel), .st_data(st_data), .be_out(be_out), .bus_wdata(bus_wdata),
        .misalign(misalign), .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // {wr, inv, big, size, offset, err, be, data}
    localparam int NV = 35;
    localparam logic [81:0] VEC [NV] = '{
        {1'b0,2'd0,1'b0,2'd0,3'd0,1'b0,8'h01,64'haa},
        {1'b0,2'd0,1'b0,2'd1,3'd0,1'b0,8'h03,64'hbbaa},
        {1'b0,2'd0,1'b0,2'd2,3'd4,1'b0,8'hf0,64'h99887766},
        {1'b0,2'd2,1'b0,2'd0,3'd0,1'b0,8'h01,64'haa},
        {1'b0,2'd0,1'b1,2'd1,3'd0,1'b0,8'h03,64'haabb},
        {1'b0,2'd0,1'b1,2'd2,3'd0,1'b0,8'h0f,64'haabbccdd},
        {1'b0,2'd0,1'b1,2'd3,3'd0,1'b0,8'hff,64'haabbccdd66778899},
        {1'b0,2'd0,1'b1,2'd1,3'd6,1'b0,8'hc0,64'h8899},
        {1'b0,2'd0,1'b1,2'd0,3'd3,1'b0,8'h08,64'hdd},
        {1'b0,2'd1,1'b1,2'd0,3'd0,1'b0,8'h02,64'hbb},
        {1'b0,2'd1,1'b1,2'd0,3'd5,1'b0,8'h10,64'h66},
        {1'b0,2'd1,1'b1,2'd1,3'd0,1'b0,8'h03,64'hbbaa},
        {1'b0,2'd1,1'b1,2'd2,3'd0,1'b0,8'h0f,64'hddccbbaa},
        {1'b0,2'd2,1'b1,2'd0,3'd0,1'b0,8'h08,64'hdd},
        {1'b0,2'd2,1'b1,2'd1,3'd0,1'b0,8'h0c,64'hddcc},
        {1'b0,2'd2,1'b1,2'd1,3'd2,1'b0,8'h03,64'hbbaa},
        {1'b0,2'd2,1'b1,2'd0,3'd4,1'b0,8'h80,64'h99},
        {1'b0,2'd2,1'b1,2'd3,3'd0,1'b0,8'hff,64'h99887766ddccbbaa},
        {1'b0,2'd3,1'b1,2'd0,3'd0,1'b0,8'h80,64'h99},
        {1'b0,2'd3,1'b1,2'd1,3'd0,1'b0,8'hc0,64'h9988},
        {1'b0,2'd3,1'b1,2'd2,3'd0,1'b0,8'hf0,64'h99887766},
        {1'b0,2'd3,1'b1,2'd2,3'd4,1'b0,8'h0f,64'hddccbbaa},
        {1'b0,2'd3,1'b1,2'd0,3'd7,1'b0,8'h01,64'haa},
        {1'b0,2'd3,1'b1,2'd3,3'd0,1'b0,8'hff,64'h99887766ddccbbaa},
        {1'b0,2'd0,1'b0,2'd1,3'd1,1'b1,8'h00,64'h0},
        {1'b0,2'd3,1'b1,2'd2,3'd2,1'b1,8'h00,64'h0},
        {1'b1,2'd0,1'b0,2'd3,3'd4,1'b1,8'h00,64'h0},
        {1'b1,2'd0,1'b1,2'd1,3'd0,1'b0,8'h03,64'h8877},
        {1'b1,2'd2,1'b1,2'd0,3'd0,1'b0,8'h08,64'h88000000},
        {1'b1,2'd3,1'b1,2'd1,3'd0,1'b0,8'hc0,64'h7788000000000000},
        {1'b1,2'd0,1'b0,2'd2,3'd4,1'b0,8'hf0,64'h5566778800000000},
        {1'b1,2'd0,1'b1,2'd2,3'd4,1'b0,8'hf0,64'h8877665500000000},
        {1'b1,2'd1,1'b1,2'd0,3'd3,1'b0,8'h04,64'h00880000},
        {1'b1,2'd3,1'b1,2'd3,3'd0,1'b0,8'hff,64'h1122334455667788},
        {1'b1,2'd0,1'b0,2'd0,3'd5,1'b0,8'h20,64'h0000880000000000}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string req_tag(input logic [81:0] v);
        if (v[72])              return "R5";
        if (v[81])              return "R6";
        if (!v[78])             return "R1";
        if (v[80:79] == 2'd0)   return "R2";
        if (v[80:79] > v[77:76]) return "R3";
        return "R4";
    endfunction

    task automatic drive(input logic wr, input logic [1:0] inv, input logic big,
                         input logic [1:0] sz, input logic [2:0] off);
        req_valid = 1'b1; req_write = wr; inv_sel = inv;
        big_endian = big; req_size = sz; req_offset = off;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: quiet during reset
        repeat (2) @(negedge clk);
        check("R9 ld_valid in reset", 64'(ld_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ld_valid after reset", 64'(ld_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = req_tag(VEC[i]);
            @(negedge clk);
            drive(VEC[i][81], VEC[i][80:79], VEC[i][78], VEC[i][77:76], VEC[i][75:73]);
            #1;
            check({t, " misalign"}, 64'(misalign), 64'(VEC[i][72]));
            check({t, "/R6 be_out"}, 64'(be_out), 64'(VEC[i][71:64]));
            if (VEC[i][81])
                check({t, "/R6 bus_wdata"}, bus_wdata, VEC[i][63:0]);
            else
                check({t, " bus_wdata zero on load"}, bus_wdata, 64'd0);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            if (!VEC[i][81] && !VEC[i][72]) begin
                check("R8 ld_valid", 64'(ld_valid), 64'd1);
                check({t, "/R7 ld_data"}, ld_data, VEC[i][63:0]);
            end else begin
                check({t, "/R8 no response"}, 64'(ld_valid), 64'd0);
            end
        end

        // R8: back-to-back loads, each with its own context
        @(negedge clk);
        drive(1'b0, 2'd2, 1'b1, 2'd0, 3'd0);   // expect dd
        @(negedge clk);
        drive(1'b0, 2'd3, 1'b1, 2'd1, 3'd0);   // expect 9988
        #1;
        check("R8 first of pair valid", 64'(ld_valid), 64'd1);
        check("R8 first of pair data", ld_data, 64'hdd);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R8 second of pair valid", 64'(ld_valid), 64'd1);
        check("R8 second of pair data", ld_data, 64'h9988);
        @(negedge clk);
        #1;
        check("R8 idle after pair", 64'(ld_valid), 64'd0);

        // R1: little-endian ignores every invariance setting
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drive(1'b0, 2'(k), 1'b0, 2'd1, 3'd2);
            #1;
            check("R1 be_out with inv_sel", 64'(be_out), 64'h0c);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            check("R1 ld_data with inv_sel", ld_data, 64'hddcc);
        end

        // R9: reset mid-response clears the response
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b0, 2'd0, 3'd0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R9 reset drops response", 64'(ld_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule